// File: doc/BRIEF.md
# Multi-cycle bit shifter and rotator with carry

This block moves an 8-bit or 16-bit operand by a programmable number of bit positions. It supports eight operations: plain rotates, rotates in which the carry flag forms one extra bit of the ring, logical shifts and arithmetic shifts. A caller presents the operand, the width, the operation, the current arithmetic flags and a count, and pulses `start`. The count comes either from an immediate byte or from a register byte.

The unit does not use a barrel shifter. It performs one single-bit step per clock, so a count of N takes N steps. The carry flag is carried from step to step, and the overflow flag reflects only the last step. When the count runs out, `done` pulses for one cycle. From that cycle on, the result and the new flags are held on the outputs until the next accepted start.

Instruction decoding and memory operands belong to the surrounding datapath and are not part of this block.

Top module: `shrot_unit`

## Requirements
- R1: `op_sel` 0 rotates left and 1 rotates right. The bit leaving one end enters the other end, and CF takes a copy of that bit. Examples: 1Ch gives 38h going left and 0Eh going right, with CF=0 in both cases.
- R2: `op_sel` 2 and 3 rotate left and right through the carry, so the operand and CF form a ring of width+1 bits. With CF=1, 1Ch gives 39h going left and 8Eh going right, with CF=0 in both cases.
- R3: `op_sel` 4 and 6 shift left and fill with zero. `op_sel` 5 shifts right and fills with zero. `op_sel` 7 shifts right and copies the sign bit. CF takes the last bit shifted out. Examples: E0h left gives C0h with CF=1; E0h arithmetic right gives F0h; 4Ch arithmetic right gives 26h; 07h logical right gives 03h with CF=1.
- R4: `cnt_from_reg`=0 takes the count from `cnt_imm` and 1 takes it from `cnt_reg`. A count of N performs N single-bit steps. If start is accepted at clock edge k, `busy` is high after edges k to k+N, and `done` is high for exactly the one cycle after edge k+N+1.
- R5: A count of 0 returns the operand (masked to the width) unchanged, returns all five flags equal to their inputs, and raises `done` one cycle after the accepted start.
- R6: For a non-zero count, OF comes from the last step, as follows:
  - after a left step (codes 0, 2, 4, 6) it is the result's top bit XOR the new CF;
  - after code 5 it is the top bit the step started with;
  - after code 7 it is 0;
  - after codes 1 and 3 it is the XOR of the result's two top bits.
- R7: For the shift codes 4 to 7 with a non-zero count, the final result sets the flags:
  - ZF is 1 for a zero result at the active width;
  - SF is the result's top bit;
  - PF is 1 when the low 8 bits hold an even number of ones.
- R8: The rotate codes 0 to 3 return ZF, SF and PF equal to their inputs.
- R9: With `word_mode`=0 only operand bits 7:0 take part. The top bit is bit 7, and result bits 15:8 read 0.
- R10: A `start` that arrives while `busy` is high is ignored.
- R11: After reset, `result`, all flag outputs, `busy` and `done` read 0.
- R12: Once `done` has pulsed, the result and the flags hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation; accepted when not busy |
| op_sel | input | 3 | Operation code (see R1 to R3) |
| word_mode | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| operand | input | 16 | Value to shift or rotate |
| cnt_from_reg | input | 1 | Count source: 0 immediate, 1 register byte |
| cnt_imm | input | 8 | Immediate count |
| cnt_reg | input | 8 | Register byte count |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| zf_in | input | 1 | Incoming zero flag |
| sf_in | input | 1 | Incoming sign flag |
| pf_in | input | 1 | Incoming parity flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted or rotated value |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| zf_out | output | 1 | New zero flag |
| sf_out | output | 1 | New sign flag |
| pf_out | output | 1 | New parity flag |

## Verification
The properties assume the following about the inputs:
- The operand, count and incoming flags are valid in the same cycle as an accepted `start`. Later changes to these inputs are ignored.
- Reset is held across at least one rising edge.

The stimulus drives every input on the falling edge and holds `start` for exactly one cycle for each operation. It pulses `start` again while the unit is busy on purpose, and each time it puts different values on the data and count pins. Counts are mostly small. One run uses the full count of 255, so the sequencer is exercised at its upper limit.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_ROTL  = 3'd0,
      OP_ROTR  = 3'd1,
      OP_RCYL  = 3'd2,
      OP_RCYR  = 3'd3,
      OP_SHL   = 3'd4,
      OP_SHR   = 3'd5,
      OP_SAL   = 3'd6,
      OP_SAR   = 3'd7
   } shrot_op_e;

   localparam int LANES = 2;

   // Shift forms occupy the upper half of the code space.
   function automatic logic is_shift(input shrot_op_e op);
      return op[2];
   endfunction

endpackage

// File: rtl/shrot_step.sv
module shrot_step #(
   parameter int W = 8
) (
   input  shrot_pkg::shrot_op_e op,
   input  logic [W-1:0]          val,
   input  logic                  cf,
   output logic [W-1:0]          nval,
   output logic                  ncf,
   output logic                  nof
);
   import shrot_pkg::*;

   if (W < 2) begin : g_bad_w
      $error("shrot_step: W must be at least 2");
   end

   always_comb begin
      nval = val;
      ncf  = cf;
      nof  = 1'b0;
      unique case (op)
         OP_ROTL: begin
            nval = {val[W-2:0], val[W-1]};
            ncf  = val[W-1];
            nof  = nval[W-1] ^ ncf;
         end
         OP_ROTR: begin
            nval = {val[0], val[W-1:1]};
            ncf  = val[0];
            nof  = nval[W-1] ^ nval[W-2];
         end
         OP_RCYL: begin
            nval = {val[W-2:0], cf};
            ncf  = val[W-1];
            nof  = nval[W-1] ^ ncf;
         end
         OP_RCYR: begin
            nval = {cf, val[W-1:1]};
            ncf  = val[0];
            nof  = nval[W-1] ^ nval[W-2];
         end
         OP_SHL, OP_SAL: begin
            nval = {val[W-2:0], 1'b0};
            ncf  = val[W-1];
            nof  = nval[W-1] ^ ncf;
         end
         OP_SHR: begin
            nval = {1'b0, val[W-1:1]};
            ncf  = val[0];
            nof  = val[W-1];
         end
         OP_SAR: begin
            nval = {val[W-1], val[W-1:1]};
            ncf  = val[0];
            nof  = 1'b0;
         end
         default: begin
            nval = val;
         end
      endcase
   end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] val,
   input  logic              wide,
   output logic              zf,
   output logic              sf,
   output logic              pf
);
   localparam int PAR_W = 8;

   if (NARROW_W < PAR_W) begin : g_bad_narrow
      $error("shrot_flags: NARROW_W must cover the parity byte");
   end

   always_comb begin
      if (wide) begin
         zf = (val == '0);
         sf = val[DATA_W-1];
      end else begin
         zf = (val[NARROW_W-1:0] == '0);
         sf = val[NARROW_W-1];
      end
      pf = ~(^val[PAR_W-1:0]);
   end

endmodule

// File: rtl/shrot_seq.sv
module shrot_seq #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   output logic             busy,
   output logic             done,
   output logic             load,
   output logic             step_en,
   output logic             finish,
   output logic             nz
);
   logic [CNT_W-1:0] rem_q;
   logic             busy_q;
   logic             done_q;
   logic             nz_q;

   assign load    = start & ~busy_q;
   assign step_en = busy_q & (rem_q != '0);
   assign finish  = busy_q & (rem_q == '0);
   assign busy    = busy_q;
   assign done    = done_q;
   assign nz      = nz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         nz_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            rem_q  <= count;
            busy_q <= 1'b1;
            nz_q   <= (count != '0);
         end else if (step_en) begin
            rem_q  <= rem_q - 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int CNT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2:0]          op_sel,
   input  logic                word_mode,
   input  logic [DATA_W-1:0]   operand,
   input  logic                cnt_from_reg,
   input  logic [CNT_W-1:0]    cnt_imm,
   input  logic [CNT_W-1:0]    cnt_reg,
   input  logic                cf_in,
   input  logic                of_in,
   input  logic                zf_in,
   input  logic                sf_in,
   input  logic                pf_in,
   output logic                busy,
   output logic                done,
   output logic [DATA_W-1:0]   result,
   output logic                cf_out,
   output logic                of_out,
   output logic                zf_out,
   output logic                sf_out,
   output logic                pf_out
);
   import shrot_pkg::*;

   if (DATA_W != 2 * NARROW_W) begin : g_bad_width
      $error("shrot_unit: DATA_W must be twice NARROW_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("shrot_unit: CNT_W must be positive");
   end

   logic [CNT_W-1:0]  cnt_pick;
   logic              load, step_en, finish, nz;
   logic [DATA_W-1:0] acc_q;
   logic              cf_q, of_q, zf_q, sf_q, pf_q;
   shrot_op_e         op_q;
   logic              wide_q;

   logic [DATA_W-1:0] lane_val [LANES];
   logic              lane_cf  [LANES];
   logic              lane_of  [LANES];
   logic              fin_zf, fin_sf, fin_pf;

   assign cnt_pick = cnt_from_reg ? cnt_reg : cnt_imm;

   shrot_seq #(.CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .count   (cnt_pick),
      .busy    (busy),
      .done    (done),
      .load    (load),
      .step_en (step_en),
      .finish  (finish),
      .nz      (nz)
   );

   // Lane 0 serves byte mode, lane 1 serves word mode.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? NARROW_W : DATA_W;
      logic [LW-1:0] nv;
      shrot_step #(.W(LW)) u_step (
         .op   (op_q),
         .val  (acc_q[LW-1:0]),
         .cf   (cf_q),
         .nval (nv),
         .ncf  (lane_cf[g]),
         .nof  (lane_of[g])
      );
      assign lane_val[g] = DATA_W'(nv);
   end

   shrot_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flags (
      .val  (acc_q),
      .wide (wide_q),
      .zf   (fin_zf),
      .sf   (fin_sf),
      .pf   (fin_pf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cf_q   <= 1'b0;
         of_q   <= 1'b0;
         zf_q   <= 1'b0;
         sf_q   <= 1'b0;
         pf_q   <= 1'b0;
         op_q   <= OP_ROTL;
         wide_q <= 1'b0;
      end else if (load) begin
         acc_q  <= word_mode ? operand : DATA_W'(operand[NARROW_W-1:0]);
         cf_q   <= cf_in;
         of_q   <= of_in;
         zf_q   <= zf_in;
         sf_q   <= sf_in;
         pf_q   <= pf_in;
         op_q   <= shrot_op_e'(op_sel);
         wide_q <= word_mode;
      end else if (step_en) begin
         acc_q  <= lane_val[wide_q];
         cf_q   <= lane_cf[wide_q];
         of_q   <= lane_of[wide_q];
      end else if (finish && nz && is_shift(op_q)) begin
         zf_q   <= fin_zf;
         sf_q   <= fin_sf;
         pf_q   <= fin_pf;
      end
   end

   assign result = acc_q;
   assign cf_out = cf_q;
   assign of_out = of_q;
   assign zf_out = zf_q;
   assign sf_out = sf_q;
   assign pf_out = pf_q;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int CNT_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [CNT_W-1:0]  cnt_pick,
   input logic              word_mode,
   input logic [DATA_W-1:0] operand,
   input logic              cf_in,
   input logic [DATA_W-1:0] result,
   input logic              cf_out,
   input logic              of_out,
   input logic              zf_out,
   input logic              sf_out,
   input logic              pf_out,
   input logic [2:0]        op_q,
   input logic              wide_q
);

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R5
   zero_cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cnt_pick == '0 && word_mode) |=> ##1
         (done && result == $past(operand, 2) && cf_out == $past(cf_in, 2)));

   // R8
   rotate_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !op_q[2]) |=> ($stable(zf_out) && $stable(sf_out) && $stable(pf_out)));

   // R9
   byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((busy || done) && !wide_q) |-> (result[DATA_W-1:NARROW_W] == '0));

   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(result) && $stable(cf_out) && $stable(of_out)));

endmodule

bind shrot_unit shrot_unit_chk #(
   .DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .cnt_pick  (cnt_pick),
   .word_mode (word_mode),
   .operand   (operand),
   .cf_in     (cf_in),
   .result    (result),
   .cf_out    (cf_out),
   .of_out    (of_out),
   .zf_out    (zf_out),
   .sf_out    (sf_out),
   .pf_out    (pf_out),
   .op_q      (op_q),
   .wide_q    (wide_q)
);

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic        word_mode = 1'b0;
   logic [15:0] operand = '0;
   logic        cnt_from_reg = 1'b0;
   logic [7:0]  cnt_imm = '0;
   logic [7:0]  cnt_reg = '0;
   logic        cf_in = 1'b0, of_in = 1'b0, zf_in = 1'b0, sf_in = 1'b0, pf_in = 1'b0;
   logic        busy, done;
   logic [15:0] result;
   logic        cf_out, of_out, zf_out, sf_out, pf_out;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shrot_unit i_shrot_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .word_mode(word_mode), .operand(operand), .cnt_from_reg(cnt_from_reg),
      .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .cf_in(cf_in), .of_in(of_in),
      .zf_in(zf_in), .sf_in(sf_in), .pf_in(pf_in), .busy(busy), .done(done),
      .result(result), .cf_out(cf_out), .of_out(of_out), .zf_out(zf_out),
      .sf_out(sf_out), .pf_out(pf_out)
   );

   task automatic chk_eq(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: walks the count one position at a time on integers.
   task automatic ref_model(input int op, input bit wide, input int v0,
                            input bit c0, input bit o0, input bit z0, input bit s0, input bit p0,
                            input int n, output int v, output bit c, output bit o,
                            output bit z, output bit s, output bit p);
      int w, mask, top;
      bit nc;
      w = wide ? 16 : 8;
      mask = (1 << w) - 1;
      top = 1 << (w - 1);
      v = v0 & mask;
      c = c0; o = o0; z = z0; s = s0; p = p0;
      for (int k = 0; k < n; k++) begin
         case (op)
            0: begin c = (v & top) != 0; v = ((v << 1) | int'(c)) & mask;
                     o = ((v & top) != 0) ^ c; end
            1: begin c = (v & 1) != 0; v = (v >> 1) | (c ? top : 0);
                     o = ((v >> (w - 1)) & 1) != ((v >> (w - 2)) & 1); end
            2: begin nc = (v & top) != 0; v = ((v << 1) | int'(c)) & mask; c = nc;
                     o = ((v & top) != 0) ^ c; end
            3: begin nc = (v & 1) != 0; v = (v >> 1) | (c ? top : 0); c = nc;
                     o = ((v >> (w - 1)) & 1) != ((v >> (w - 2)) & 1); end
            4, 6: begin c = (v & top) != 0; v = (v << 1) & mask;
                     o = ((v & top) != 0) ^ c; end
            5: begin o = (v & top) != 0; c = (v & 1) != 0; v = v >> 1; end
            default: begin c = (v & 1) != 0; v = (v >> 1) | (v & top); o = 1'b0; end
         endcase
      end
      if (n > 0 && op >= 4) begin
         z = (v == 0);
         s = (v & top) != 0;
         p = ($countones(v & 255) % 2) == 0;
      end
   endtask

   function automatic string op_tag(input int op);
      if (op < 2) return "R1";
      if (op < 4) return "R2";
      return "R3";
   endfunction

   task automatic run_op(input int op, input bit wide, input int val,
                         input bit c0, input bit o0, input bit z0, input bit s0, input bit p0,
                         input bit from_reg, input int n, input bit poke);
      int ev; bit ec, eo, ez, es, ep;
      string rt, ft, ot;
      int held;
      ref_model(op, wide, val, c0, o0, z0, s0, p0, n, ev, ec, eo, ez, es, ep);
      rt = (n == 0) ? "R5" : op_tag(op);
      ot = (n == 0) ? "R5" : "R6";
      ft = (n == 0) ? "R5" : ((op >= 4) ? "R7" : "R8");
      op_sel = 3'(op); word_mode = wide; operand = 16'(val);
      cnt_from_reg = from_reg;
      cnt_imm = from_reg ? 8'(n + 3) : 8'(n);
      cnt_reg = from_reg ? 8'(n) : 8'(n + 5);
      cf_in = c0; of_in = o0; zf_in = z0; sf_in = s0; pf_in = p0;
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      chk_eq("R4", "busy after accept", int'(busy), 1);
      for (int i = 1; i <= n + 1; i++) begin
         if (poke && i == 1) begin
            // R10: a second request while busy must not disturb the run
            start = 1'b1; operand = ~operand; op_sel = ~op_sel;
            cnt_imm = 8'd2; cnt_reg = 8'd2; cf_in = ~cf_in;
         end
         @(posedge clk); @(negedge clk);
         start = 1'b0;
         chk_eq(poke ? "R10" : "R4", "done timing", int'(done), int'(i == n + 1));
         chk_eq(poke ? "R10" : "R4", "busy timing", int'(busy), int'(i <= n));
      end
      chk_eq(rt, "result", int'(result), ev);
      chk_eq(rt, "cf", int'(cf_out), int'(ec));
      chk_eq(ot, "of", int'(of_out), int'(eo));
      chk_eq(ft, "zf", int'(zf_out), int'(ez));
      chk_eq(ft, "sf", int'(sf_out), int'(es));
      chk_eq(ft, "pf", int'(pf_out), int'(ep));
      if (!wide) chk_eq("R9", "upper byte", int'(result[15:8]), 0);
      held = int'(result);
      @(posedge clk); @(negedge clk);
      chk_eq("R12", "done dropped", int'(done), 0);
      chk_eq("R12", "result held", int'(result), held);
      chk_eq("R12", "cf held", int'(cf_out), int'(ec));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      chk_eq("R11", "result", int'(result), 0);
      chk_eq("R11", "flags", int'({cf_out, of_out, zf_out, sf_out, pf_out}), 0);
      chk_eq("R11", "busy/done", int'({busy, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // single steps on the byte examples
      run_op(2, 0, 'h1C, 1, 0, 0, 0, 0, 0, 1, 0);   // R2
      run_op(3, 0, 'h1C, 1, 0, 0, 0, 0, 0, 1, 0);   // R2
      run_op(0, 0, 'h1C, 0, 0, 0, 0, 0, 0, 1, 0);   // R1
      run_op(1, 0, 'h1C, 0, 0, 0, 0, 0, 0, 1, 0);   // R1
      run_op(4, 0, 'hE0, 0, 0, 0, 0, 0, 0, 1, 0);   // R3
      run_op(6, 0, 'hE0, 0, 0, 0, 0, 0, 0, 1, 0);   // R3
      run_op(7, 0, 'hE0, 0, 0, 0, 0, 0, 0, 1, 0);   // R3
      run_op(7, 0, 'h4C, 0, 0, 0, 0, 0, 0, 1, 0);   // R3
      run_op(5, 0, 'h07, 0, 0, 0, 0, 0, 1, 1, 0);   // R3
      // multi-step runs and count sources (R4)
      run_op(0, 1, 'h8001, 0, 0, 1, 1, 1, 1, 4, 0);
      run_op(3, 1, 'hA5C3, 1, 0, 0, 0, 0, 0, 17, 0);
      run_op(5, 0, 'hFF5A, 1, 1, 0, 1, 0, 1, 9, 0);
      run_op(7, 1, 'h8000, 0, 0, 0, 0, 0, 0, 255, 0);
      // count zero (R5), byte mode upper bits (R9)
      run_op(4, 1, 'hBEEF, 1, 1, 1, 1, 1, 0, 0, 0);
      run_op(1, 0, 'h1234, 0, 1, 0, 1, 0, 1, 0, 0);
      // start while busy (R10)
      run_op(2, 1, 'h4321, 0, 0, 1, 0, 1, 0, 3, 1);
      run_op(5, 0, 'h0081, 1, 0, 0, 0, 0, 1, 0, 1);
      // mixed stimulus
      for (int t = 0; t < 60; t++) begin
         run_op(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 20)),
                1'($urandom_range(0, 3) == 0));
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule